// File: doc/BRIEF.md
# Palette DAC Host Register File with Hidden Command Register

This block is the register file that a host processor uses to program a palette DAC with a hardware cursor. The host drives a 4-bit register address with byte-wide read and write strobes. The block decodes that address into three directly visible command registers, a write-address register, a status port, four cursor position registers, a cursor colour address and data port pair, and a cursor RAM data port. The decoded control fields go out as plain signals to the display path. Write strobes for the 1024-byte cursor RAM and the small cursor colour table leave the block together with their addresses.

A fourth command register has no address of its own. The host sets the window-enable bit (bit 7) of command register 0 and loads index 0 into the write-address register. The status port then reads and writes that hidden register. The two low bits of the hidden register sit above the 8-bit write address and form a 10-bit cursor RAM pointer. Every cursor data write advances that pointer, so a full cursor image is 1024 back-to-back writes from pointer 0.

Cursor colours are loaded through their own address port. Each entry takes three data writes, which are red, green and blue in that order. After the third write the address moves on to the next entry.

Top module: `dac_host_regs`

## Requirements
- R1: After reset every register reads 0, and all exported control fields and position outputs are 0.
- R2: While bit 7 of command register 0 (address 1) is 0, a read of the status port (address 4) returns `status_in`.
- R3: While bit 7 of command register 0 is 1 and the write-address register (address 0) holds 0, the status port reads and writes the hidden command register. With any other index, the status port reads 0 and its writes change nothing.
- R4: The cursor RAM pointer is {hidden register bits 1:0, write-address register}, which gives 10 bits. Bit 2 of the hidden register drives `cursor_64`.
- R5: A write to the cursor data port (address 11) raises `cram_we` in that cycle, with `cram_addr` equal to the pointer and `cram_wdata` equal to the written byte. The pointer then advances by one modulo 1024, and the carry is visible in hidden register bits 1:0 and in the write-address register.
- R6: A write to the colour address port (address 9) sets the entry index from bits 1:0 and returns the component counter to red.
- R7: Writes to the colour data port (address 10) raise `ctab_we` with component 0, 1 and then 2 (red, green, blue). After blue, the entry index advances by one modulo 4.
- R8: The position registers are X low (5), X high (6), Y low (7) and Y high (8). The high registers keep only bits 3:0 and read 0 in bits 7:4. `cursor_x` and `cursor_y` are {high[3:0], low}.
- R9: Command register 2 (address 3) drives `cursor_mode` from bits 1:0 and `cursor_interlace` from bit 3.
- R10: Command register 0 drives `dac_8bit` from bit 1 and `sync_on_green` from bit 3.
- R11: Register reads return the stored value, and command register 1 is at address 2. The two data ports (10, 11) and unmapped addresses (12 to 15) read 0. `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| status_in | input | 8 | Ordinary status value |
| cram_we | output | 1 | Cursor RAM write enable |
| cram_addr | output | 10 | Cursor RAM byte address |
| cram_wdata | output | 8 | Cursor RAM write data |
| ctab_we | output | 1 | Colour table write enable |
| ctab_idx | output | 2 | Colour entry index |
| ctab_comp | output | 2 | Colour component (0 red, 1 green, 2 blue) |
| ctab_wdata | output | 8 | Colour component value |
| dac_8bit | output | 1 | 8-bit colour data select |
| sync_on_green | output | 1 | Sync on green enable |
| cursor_mode | output | 2 | Cursor mode |
| cursor_interlace | output | 1 | Interlaced cursor handling |
| cursor_64 | output | 1 | 64x64 cursor size |
| cursor_x | output | 12 | Cursor X position |
| cursor_y | output | 12 | Cursor Y position |

## Verification
The bench writes a full 1024-byte cursor image starting from pointer 0. This separates a correct 10-bit carry into the hidden register from a pointer that wraps at 256 or never increments. It loads three colour entries and reloads the colour address partway through an entry, which shows whether the component counter restarts. Directed accesses to the status window with the enable bit on and off, and with index 0 or a nonzero index, separate the plain status path from the hidden register path. Seeded random reads and writes across all addresses, compared with a bench model, catch decode slips and lost field bits.

// File: rtl/dac_host_regs.sv
module dac_host_regs #(
  parameter int AW = 4,
  parameter int NCOL = 4,
  parameter int POS_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             reg_addr,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [7:0]                wr_data,
  output logic [7:0]                rd_data,
  input  logic [7:0]                status_in,
  output logic                      cram_we,
  output logic [9:0]                cram_addr,
  output logic [7:0]                cram_wdata,
  output logic                      ctab_we,
  output logic [$clog2(NCOL)-1:0]   ctab_idx,
  output logic [1:0]                ctab_comp,
  output logic [7:0]                ctab_wdata,
  output logic                      dac_8bit,
  output logic                      sync_on_green,
  output logic [1:0]                cursor_mode,
  output logic                      cursor_interlace,
  output logic                      cursor_64,
  output logic [POS_W-1:0]          cursor_x,
  output logic [POS_W-1:0]          cursor_y
);
  localparam int CW = $clog2(NCOL);
  localparam int HW = POS_W - 8;

  localparam logic [AW-1:0] A_WADDR  = AW'(0);
  localparam logic [AW-1:0] A_CMD0   = AW'(1);
  localparam logic [AW-1:0] A_CMD1   = AW'(2);
  localparam logic [AW-1:0] A_CMD2   = AW'(3);
  localparam logic [AW-1:0] A_STATUS = AW'(4);
  localparam logic [AW-1:0] A_XLO    = AW'(5);
  localparam logic [AW-1:0] A_XHI    = AW'(6);
  localparam logic [AW-1:0] A_YLO    = AW'(7);
  localparam logic [AW-1:0] A_YHI    = AW'(8);
  localparam logic [AW-1:0] A_CADDR  = AW'(9);
  localparam logic [AW-1:0] A_CDATA  = AW'(10);
  localparam logic [AW-1:0] A_CRAM   = AW'(11);

  logic [7:0]    cmd0, cmd1, cmd2, cmd3, waddr;
  logic [7:0]    xlo, ylo;
  logic [HW-1:0] xhi, yhi;
  logic [CW-1:0] col_idx;
  logic [1:0]    col_comp;

  logic       win_on, win_hit;
  logic [9:0] cram_next;

  assign win_on    = cmd0[7];
  assign win_hit   = win_on && (waddr == 8'd0);
  assign cram_addr = {cmd3[1:0], waddr};
  assign cram_next = cram_addr + 10'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd0 <= '0; cmd1 <= '0; cmd2 <= '0; cmd3 <= '0; waddr <= '0;
      xlo <= '0; ylo <= '0; xhi <= '0; yhi <= '0;
      col_idx <= '0; col_comp <= '0;
    end else if (wr_en) begin
      case (reg_addr)
        A_WADDR:  waddr <= wr_data;
        A_CMD0:   cmd0 <= wr_data;
        A_CMD1:   cmd1 <= wr_data;
        A_CMD2:   cmd2 <= wr_data;
        A_STATUS: if (win_hit) cmd3 <= wr_data;
        A_XLO:    xlo <= wr_data;
        A_XHI:    xhi <= wr_data[HW-1:0];
        A_YLO:    ylo <= wr_data;
        A_YHI:    yhi <= wr_data[HW-1:0];
        A_CADDR: begin
          col_idx  <= wr_data[CW-1:0];
          col_comp <= 2'd0;
        end
        A_CDATA: begin
          if (col_comp == 2'd2) begin
            col_comp <= 2'd0;
            col_idx  <= col_idx + CW'(1);
          end else begin
            col_comp <= col_comp + 2'd1;
          end
        end
        A_CRAM: begin
          cmd3[1:0] <= cram_next[9:8];
          waddr     <= cram_next[7:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = 8'd0;
    if (rd_en) begin
      case (reg_addr)
        A_WADDR:  rd_data = waddr;
        A_CMD0:   rd_data = cmd0;
        A_CMD1:   rd_data = cmd1;
        A_CMD2:   rd_data = cmd2;
        A_STATUS: rd_data = win_on ? (win_hit ? cmd3 : 8'd0) : status_in;
        A_XLO:    rd_data = xlo;
        A_XHI:    rd_data = 8'(xhi);
        A_YLO:    rd_data = ylo;
        A_YHI:    rd_data = 8'(yhi);
        A_CADDR:  rd_data = 8'(col_idx);
        default:  rd_data = 8'd0;
      endcase
    end
  end

  assign cram_we    = wr_en && (reg_addr == A_CRAM);
  assign cram_wdata = wr_data;
  assign ctab_we    = wr_en && (reg_addr == A_CDATA);
  assign ctab_idx   = col_idx;
  assign ctab_comp  = col_comp;
  assign ctab_wdata = wr_data;

  assign dac_8bit         = cmd0[1];
  assign sync_on_green    = cmd0[3];
  assign cursor_mode      = cmd2[1:0];
  assign cursor_interlace = cmd2[3];
  assign cursor_64        = cmd3[2];
  assign cursor_x         = {xhi, xlo};
  assign cursor_y         = {yhi, ylo};
endmodule

// File: rtl/dac_host_regs_chk.sv
module dac_host_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  rd_data,
  input logic [7:0]  status_in,
  input logic [7:0]  cmd0,
  input logic        cram_we,
  input logic [9:0]  cram_addr,
  input logic        ctab_we,
  input logic [1:0]  ctab_idx,
  input logic [1:0]  ctab_comp
);
  p_cram_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cram_we |=> (cram_addr == $past(cram_addr) + 10'd1));

  p_comp_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctab_we && ctab_comp == 2'd2) |=>
      (ctab_comp == 2'd0 && ctab_idx == $past(ctab_idx) + 2'd1));

  p_comp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctab_comp != 2'd3);

  p_caddr_red_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 4'd9) |=> (ctab_comp == 2'd0));

  p_hi_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (reg_addr == 4'd6 || reg_addr == 4'd8)) |-> (rd_data[7:4] == 4'd0));

  p_plain_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == 4'd4 && !cmd0[7]) |-> (rd_data == status_in));

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == 8'd0));
endmodule

bind dac_host_regs dac_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .status_in(status_in), .cmd0(cmd0),
  .cram_we(cram_we), .cram_addr(cram_addr),
  .ctab_we(ctab_we), .ctab_idx(ctab_idx), .ctab_comp(ctab_comp)
);

// File: tb/dac_host_regs_bench.sv
`timescale 1ns/1ps
module dac_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0, status_in = 8'h5A;
  logic [7:0]  rd_data;
  logic        cram_we, ctab_we;
  logic [9:0]  cram_addr;
  logic [7:0]  cram_wdata, ctab_wdata;
  logic [1:0]  ctab_idx, ctab_comp, cursor_mode;
  logic        dac_8bit, sync_on_green, cursor_interlace, cursor_64;
  logic [11:0] cursor_x, cursor_y;

  always #5 clk = ~clk;

  dac_host_regs u_dac_host_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .status_in(status_in),
    .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata),
    .ctab_we(ctab_we), .ctab_idx(ctab_idx), .ctab_comp(ctab_comp), .ctab_wdata(ctab_wdata),
    .dac_8bit(dac_8bit), .sync_on_green(sync_on_green), .cursor_mode(cursor_mode),
    .cursor_interlace(cursor_interlace), .cursor_64(cursor_64),
    .cursor_x(cursor_x), .cursor_y(cursor_y)
  );

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  logic [7:0] m_cmd [4];
  logic [7:0] m_wa, m_xlo, m_ylo;
  logic [3:0] m_xhi, m_yhi;
  logic [1:0] m_ci, m_cc;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return m_wa;
      4'd1: return m_cmd[0];
      4'd2: return m_cmd[1];
      4'd3: return m_cmd[2];
      4'd4: return m_cmd[0][7] ? ((m_wa == 8'd0) ? m_cmd[3] : 8'd0) : status_in;
      4'd5: return m_xlo;
      4'd6: return {4'd0, m_xhi};
      4'd7: return m_ylo;
      4'd8: return {4'd0, m_yhi};
      4'd9: return {6'd0, m_ci};
      default: return 8'd0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_cmd[i] = '0;
    m_wa = '0; m_xlo = '0; m_ylo = '0; m_xhi = '0; m_yhi = '0; m_ci = '0; m_cc = '0;
  endtask

  task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
    logic [9:0] p;
    case (a)
      4'd0: m_wa = d;
      4'd1: m_cmd[0] = d;
      4'd2: m_cmd[1] = d;
      4'd3: m_cmd[2] = d;
      4'd4: if (m_cmd[0][7] && m_wa == 8'd0) m_cmd[3] = d;
      4'd5: m_xlo = d;
      4'd6: m_xhi = d[3:0];
      4'd7: m_ylo = d;
      4'd8: m_yhi = d[3:0];
      4'd9: begin m_ci = d[1:0]; m_cc = 2'd0; end
      4'd10: if (m_cc == 2'd2) begin m_cc = 2'd0; m_ci = m_ci + 2'd1; end
             else m_cc = m_cc + 2'd1;
      4'd11: begin
        p = {m_cmd[3][1:0], m_wa} + 10'd1;
        m_cmd[3][1:0] = p[9:8];
        m_wa = p[7:0];
      end
      default: ;
    endcase
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit strict);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    #1;
    if (a == 4'd11) begin
      if (strict) check("R5 cram_we", cram_we, 1);
      check("R5 cram_addr", cram_addr, {m_cmd[3][1:0], m_wa});
      if (strict) check("R5 cram_wdata", cram_wdata, d);
    end
    if (a == 4'd10) begin
      check("R7 ctab_idx", ctab_idx, m_ci);
      check("R7 ctab_comp", ctab_comp, m_cc);
      if (strict) check("R7 ctab_wdata", ctab_wdata, d);
    end
    @(posedge clk);
    model_wr(a, d);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    @(negedge clk);
    reg_addr = a; wr_en = 1'b0; rd_en = 1'b1;
    #1 check(req, rd_data, exp_read(a));
    rd_en = 1'b0;
  endtask

  task automatic chk_outs(input string req);
    check({req, " fields"},
          {dac_8bit, sync_on_green, cursor_mode, cursor_interlace, cursor_64},
          {m_cmd[0][1], m_cmd[0][3], m_cmd[2][1:0], m_cmd[2][3], m_cmd[3][2]});
    check({req, " pos"}, {cursor_x, cursor_y}, {m_xhi, m_xlo, m_yhi, m_ylo});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) if (a != 4) rd(4'(a), "R1 reset read");
    chk_outs("R1");
    // R11 idle read is 0
    @(negedge clk); reg_addr = 4'd4; rd_en = 1'b0; #1 check("R11 idle", rd_data, 0);

    // R2 plain status
    status_in = 8'hC3; rd(4'd4, "R2 status");

    // R3 hidden register via window
    wr(4'd1, 8'h80, 1); wr(4'd0, 8'h00, 1);
    wr(4'd4, 8'h04, 1); rd(4'd4, "R3 hidden read");
    check("R4 cursor_64", cursor_64, 1);
    wr(4'd0, 8'h07, 1); rd(4'd4, "R3 other index reads 0");
    wr(4'd4, 8'hFF, 1); wr(4'd0, 8'h00, 1); rd(4'd4, "R3 other index write ignored");
    wr(4'd1, 8'h0A, 1); status_in = 8'h3C; rd(4'd4, "R2 window off");
    chk_outs("R10");

    // R4/R5 full cursor load from 0
    wr(4'd0, 8'h00, 1);
    for (int i = 0; i < 1024; i++) begin
      wr(4'd11, 8'(i * 7 + 3), 1);
      if (i == 255) rd(4'd0, "R5 wa after 256");
    end
    rd(4'd0, "R5 wrap to 0");
    wr(4'd1, 8'h80, 1); rd(4'd4, "R4 hidden after wrap");
    wr(4'd4, 8'h06, 1); wr(4'd1, 8'h00, 1); wr(4'd0, 8'hFF, 1);
    wr(4'd11, 8'h11, 1); rd(4'd0, "R5 carry");
    wr(4'd1, 8'h80, 1); wr(4'd0, 8'h00, 1); rd(4'd4, "R5 carry into hidden");
    wr(4'd1, 8'h00, 1);

    // R6/R7 colour table
    wr(4'd9, 8'h01, 1);
    for (int i = 0; i < 6; i++) wr(4'd10, 8'(8'h20 + i), 1);
    rd(4'd9, "R7 index after two entries");
    wr(4'd10, 8'h40, 1); wr(4'd9, 8'h02, 1);
    wr(4'd10, 8'h41, 1);
    wr(4'd9, 8'h03, 1);
    for (int i = 0; i < 3; i++) wr(4'd10, 8'h50, 1);
    rd(4'd9, "R7 index wrap");

    // R8 positions
    wr(4'd5, 8'h34, 1); wr(4'd6, 8'hF2, 1); wr(4'd7, 8'h9A, 1); wr(4'd8, 8'hAB, 1);
    rd(4'd6, "R8 x hi masked"); rd(4'd8, "R8 y hi masked");
    chk_outs("R8");

    // R9 cursor control
    wr(4'd3, 8'h0B, 1); chk_outs("R9"); rd(4'd3, "R9 read");
    wr(4'd2, 8'hA5, 1); rd(4'd2, "R11 cmd1");
    rd(4'd10, "R11 colour data reads 0"); rd(4'd11, "R11 cram data reads 0");

    // random phase
    void'($urandom(32'h2468ACE1));
    for (int n = 0; n < 600; n++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) status_in = 8'($urandom);
      if ($urandom_range(0, 1) == 0) wr(a, 8'($urandom), 0);
      else rd(a, "R11 random read");
      if (n % 8 == 0) chk_outs("R11 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule